// File: doc/BRIEF.md
# Tagged Sequential Prefetch Engine

This engine watches the demand lookups of a cache and turns them into next-block prefetch requests. Each accepted lookup carries a block address, whether the lookup hit, and the state of the hit line's one-bit "prefetched, not yet used" marker. In tagged mode, a demand miss or the first demand hit to a marked line starts a burst. The burst walks the blocks above the trigger block in ascending order. For each one it asks the cache through a presence port whether the block is already resident. Only absent blocks are sent out on a valid/ready request port. In prefetch-on-miss mode, only misses trigger, and the burst covers a single block.

The number of blocks looked at per trigger is a runtime degree from 1 to 8. It is captured when the burst starts. One candidate is resolved per cycle. While a burst runs, the engine drops its accept signal, so the next lookup waits. The engine also tells the cache which marker to clear: that happens when a marked line sees its first demand hit. It also gives the marker value that a prefetch fill must store. Block addresses are unsigned. A candidate above the highest block address is dropped and is not wrapped around to zero.

Top module: `seq_prefetch_engine`

## Requirements
- R1: While reset is asserted, acc_ready_o is 1 and req_valid_o is 0.
- R2: A candidate block for which probe_present_i is 1 produces no request. It still uses up its cycle.
- R3: With mode_i = 0 (prefetch-on-miss), an accepted miss to block b makes b+1 the only candidate, whatever degree_i is. Hits, including hits with acc_tag_i = 1, start nothing and raise no tag_clr_o.
- R4: With mode_i = 1 (tagged), an accepted miss starts a burst.
- R5: With mode_i = 1, an accepted hit with acc_tag_i = 1 starts a burst. In that same cycle it raises tag_clr_o with tag_clr_addr_o equal to acc_addr_i. A hit with acc_tag_i = 0 does nothing.
- R6: A burst for block b with degree K resolves candidates b+1 up to b+K in ascending order, at most one per cycle. req_addr_o equals the candidate.
- R7: degree_i is captured on the trigger cycle. A value of 0 acts as 1, and values above 8 act as 8. Later changes do not affect a running burst.
- R8: fill_tag_o equals mode_i, which is the marker value the cache stores for a prefetched line.
- R9: acc_ready_o is 0 from the cycle after a trigger until the burst ends. A lookup is only taken in a cycle where acc_ready_o is 1.
- R10: A candidate whose address exceeds 2^ADDR_W - 1 is suppressed and issues no request.
- R11: While req_ready_i is 0, a pending request keeps req_valid_o = 1 and the same req_addr_o.
- R12: The first candidate is presented in the cycle after the trigger is accepted. acc_ready_o returns in the cycle after the last candidate is resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = prefetch-on-miss, 1 = tagged |
| degree_i | input | $clog2(MAX_DEGREE+1) | Lookahead degree requested |
| acc_valid_i | input | 1 | Demand lookup present |
| acc_ready_o | output | 1 | Engine can take a lookup |
| acc_addr_i | input | ADDR_W | Block address of the lookup |
| acc_hit_i | input | 1 | Lookup hit |
| acc_tag_i | input | 1 | Marker of the hit line |
| tag_clr_o | output | 1 | Clear the marker of the hit line |
| tag_clr_addr_o | output | ADDR_W | Block whose marker is cleared |
| probe_valid_o | output | 1 | Presence query active |
| probe_addr_o | output | ADDR_W | Block being queried |
| probe_present_i | input | 1 | Queried block is resident |
| req_valid_o | output | 1 | Prefetch request valid |
| req_ready_i | input | 1 | Memory side takes the request |
| req_addr_o | output | ADDR_W | Block to prefetch |
| fill_tag_o | output | 1 | Marker value for the filled line |

## Verification
The hardest case to reach is a marker-set line that gets its first demand hit. Only a prefetch fill in tagged mode leaves a line in that state. The stimulus therefore runs a burst first and then hits the block it produced. It also switches to prefetch-on-miss mode before such a hit, to show that the marker is ignored there. Bursts that mix resident and absent candidates come from preloading chosen blocks into the bench's cache model. Addresses near the top of the address space push candidates past the highest block. A random phase with stalled requests and changing degrees runs against a cycle-level model of the cache and the engine.

// File: rtl/seq_pf_pkg.sv
`timescale 1ns/1ps
package seq_pf_pkg;
  typedef enum logic {
    PF_ON_MISS = 1'b0,
    PF_TAGGED  = 1'b1
  } pf_mode_e;
endpackage

// File: rtl/seq_pf_trigger.sv
`timescale 1ns/1ps
module seq_pf_trigger
  import seq_pf_pkg::*;
#(
  parameter int MAX_DEGREE = 8,
  parameter int DEG_W      = 4
) (
  input  logic             accept_i,
  input  pf_mode_e         mode_i,
  input  logic             hit_i,
  input  logic             tag_i,
  input  logic [DEG_W-1:0] degree_i,
  output logic             fire_o,
  output logic             clr_o,
  output logic [DEG_W-1:0] k_o
);
  localparam logic [DEG_W-1:0] KMax = DEG_W'(MAX_DEGREE);
  localparam logic [DEG_W-1:0] KOne = DEG_W'(1);

  logic first_use;
  assign first_use = (mode_i == PF_TAGGED) && hit_i && tag_i;

  always_comb begin
    fire_o = accept_i && (!hit_i || first_use);
    clr_o  = accept_i && first_use;
    if (mode_i == PF_ON_MISS || degree_i == '0) k_o = KOne;
    else if (degree_i > KMax)                   k_o = KMax;
    else                                        k_o = degree_i;
  end
endmodule

// File: rtl/seq_pf_burst.sv
`timescale 1ns/1ps
module seq_pf_burst #(
  parameter int ADDR_W     = 32,
  parameter int MAX_DEGREE = 8,
  parameter int DEG_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DEG_W-1:0]  k_i,
  input  logic              present_i,
  input  logic              req_ready_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] base_q;
  logic [DEG_W-1:0]  cnt_q, k_q;
  logic [ADDR_W:0]   sum;
  logic              wrap, advance, last;

  assign sum     = {1'b0, base_q} + (ADDR_W+1)'(cnt_q);
  assign wrap    = sum[ADDR_W];
  assign last    = (cnt_q == k_q);
  // wrapped or resident candidates cost one cycle and issue nothing
  assign advance = busy_q && (wrap || present_i || req_ready_i);

  assign busy_o       = busy_q;
  assign probe_addr_o = sum[ADDR_W-1:0];
  assign req_addr_o   = sum[ADDR_W-1:0];
  assign req_valid_o  = busy_q && !wrap && !present_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      k_q    <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      base_q <= base_i;
      cnt_q  <= DEG_W'(1);
      k_q    <= k_i;
    end else if (advance) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + DEG_W'(1);
    end
  end

  AST_REQ_NOT_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !present_i);  // R2
  AST_REQ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ((req_addr_o - base_q) != '0) &&
                    ((req_addr_o - base_q) <= ADDR_W'(k_q)));  // R6
  AST_DEGREE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (k_q >= DEG_W'(1)) && (k_q <= DEG_W'(MAX_DEGREE)));  // R7
  AST_NO_WRAP_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o > base_q));  // R10
  AST_BURST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && last && !start_i) |=> !busy_q);  // R12
endmodule

// File: rtl/seq_prefetch_engine.sv
`timescale 1ns/1ps
module seq_prefetch_engine
  import seq_pf_pkg::*;
#(
  parameter int  ADDR_W     = 32,
  parameter int  MAX_DEGREE = 8,
  localparam int DegW       = $clog2(MAX_DEGREE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [DegW-1:0]   degree_i,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_hit_i,
  input  logic              acc_tag_i,
  output logic              tag_clr_o,
  output logic [ADDR_W-1:0] tag_clr_addr_o,
  output logic              probe_valid_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  input  logic              probe_present_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              fill_tag_o
);
  pf_mode_e        mode;
  logic            busy, accept, fire;
  logic [DegW-1:0] k_eff;

  assign mode           = pf_mode_e'(mode_i);
  assign acc_ready_o    = !busy;
  assign accept         = acc_valid_i && !busy;
  assign tag_clr_addr_o = acc_addr_i;
  assign probe_valid_o  = busy;
  assign fill_tag_o     = (mode == PF_TAGGED);

  seq_pf_trigger #(
    .MAX_DEGREE(MAX_DEGREE),
    .DEG_W     (DegW)
  ) u_trigger (
    .accept_i(accept),
    .mode_i  (mode),
    .hit_i   (acc_hit_i),
    .tag_i   (acc_tag_i),
    .degree_i(degree_i),
    .fire_o  (fire),
    .clr_o   (tag_clr_o),
    .k_o     (k_eff)
  );

  seq_pf_burst #(
    .ADDR_W    (ADDR_W),
    .MAX_DEGREE(MAX_DEGREE),
    .DEG_W     (DegW)
  ) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (fire),
    .base_i      (acc_addr_i),
    .k_i         (k_eff),
    .present_i   (probe_present_i),
    .req_ready_i (req_ready_i),
    .busy_o      (busy),
    .probe_addr_o(probe_addr_o),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o)
  );

  AST_TRIGGER_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !acc_ready_o);  // R9
  AST_CLR_NEEDS_MARKED_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_clr_o |-> acc_hit_i && acc_tag_i && mode_i && acc_ready_o);  // R5
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && $stable(probe_present_i)) |=>
      req_valid_o && $stable(req_addr_o));  // R11
endmodule

// File: tb/seq_prefetch_engine_tb.sv
`timescale 1ns/1ps
module seq_prefetch_engine_tb;
  localparam int AW    = 8;
  localparam int NBLK  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b1;
  logic [3:0]    degree = 4'd1;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          req_ready = 1'b1;
  logic          acc_ready, tag_clr, probe_valid, req_valid, fill_tag;
  logic [AW-1:0] tag_clr_addr, probe_addr, req_addr;
  logic          acc_hit, acc_tag, probe_present;

  bit present [NBLK];
  bit tagb    [NBLK];
  int cq[$];
  int pre_q[$];
  bit flush_req = 0;
  bit ready_rand = 0;
  bit checking = 0;
  int hs_cnt = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign acc_hit       = present[acc_addr];
  assign acc_tag       = tagb[acc_addr];
  assign probe_present = present[probe_addr];

  seq_prefetch_engine #(.ADDR_W(AW), .MAX_DEGREE(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .degree_i(degree),
    .acc_valid_i(acc_valid), .acc_ready_o(acc_ready), .acc_addr_i(acc_addr),
    .acc_hit_i(acc_hit), .acc_tag_i(acc_tag),
    .tag_clr_o(tag_clr), .tag_clr_addr_o(tag_clr_addr),
    .probe_valid_o(probe_valid), .probe_addr_o(probe_addr),
    .probe_present_i(probe_present),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .fill_tag_o(fill_tag)
  );

  function automatic void chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
    end
  endfunction

  // reference model: cache contents plus queue of pending candidates (-1 = past top)
  always @(posedge clk) begin
    int f, a, k;
    bit trig;
    if (!rst_n) begin
      cq.delete();
    end else begin
      if (flush_req) begin
        for (int i = 0; i < NBLK; i++) begin present[i] <= 1'b0; tagb[i] <= 1'b0; end
        flush_req = 0;
      end
      while (pre_q.size() > 0) begin
        f = pre_q.pop_front();
        present[f] <= 1'b1;
        tagb[f]    <= 1'b0;
      end
      if (cq.size() > 0) begin
        f = cq[0];
        if (f < 0 || present[f]) void'(cq.pop_front());
        else if (req_ready) begin
          present[f] <= 1'b1;
          tagb[f]    <= mode;
          void'(cq.pop_front());
        end
      end else if (acc_valid) begin
        a = int'(acc_addr);
        trig = 0;
        if (!present[a]) begin
          present[a] <= 1'b1; tagb[a] <= 1'b0; trig = 1;
        end else if (mode && tagb[a]) begin
          tagb[a] <= 1'b0; trig = 1;
        end
        if (trig) begin
          if (!mode || degree == 0) k = 1;
          else if (degree > 8)      k = 8;
          else                      k = int'(degree);
          for (int i = 1; i <= k; i++) cq.push_back((a + i < NBLK) ? a + i : -1);
        end
      end
    end
  end

  always @(negedge clk) begin
    bit er, ev, ec;
    int ea;
    if (rst_n && checking) begin
      er = (cq.size() == 0);
      ev = 0; ea = 0;
      if (!er && cq[0] >= 0 && !present[cq[0]]) begin ev = 1; ea = cq[0]; end
      chk(acc_ready == er, "R9 R12 acc_ready", int'(acc_ready), int'(er));
      chk(req_valid == ev, "R2 R6 R10 R11 req_valid", int'(req_valid), int'(ev));
      if (ev) chk(int'(req_addr) == ea, "R6 R11 req_addr", int'(req_addr), ea);
      chk(fill_tag == mode, "R8 fill_tag", int'(fill_tag), int'(mode));
      ec = er && acc_valid && mode && present[acc_addr] && tagb[acc_addr];
      chk(tag_clr == ec, "R3 R5 tag_clr", int'(tag_clr), int'(ec));
      if (ec) chk(tag_clr_addr == acc_addr, "R5 tag_clr_addr", int'(tag_clr_addr), int'(acc_addr));
      if (req_valid && req_ready) hs_cnt++;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      req_ready = ready_rand ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  end

  task automatic access(input int a);
    bit seen;
    acc_addr  = AW'(a);
    acc_valid = 1'b1;
    forever begin
      @(negedge clk); seen = acc_ready;
      @(posedge clk); #1;
      if (seen) break;
    end
    acc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(acc_ready && cq.size() == 0));
  endtask

  task automatic flush();
    wait_idle();
    flush_req = 1;
    @(posedge clk); #1;
  endtask

  task automatic preload(input int p);
    pre_q.push_back(p);
    @(posedge clk); #1;
  endtask

  task automatic run_case(input int a, input int exp, input string what);
    hs_cnt = 0;
    access(a);
    wait_idle();
    chk(hs_cnt == exp, what, hs_cnt, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_ready == 1'b1, "R1 reset acc_ready", int'(acc_ready), 1);
    chk(req_valid == 1'b0, "R1 reset req_valid", int'(req_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    checking = 1;
    repeat (2) @(posedge clk); #1;

    // R3: prefetch-on-miss ignores degree and hits
    mode = 1'b0; degree = 4'd4;
    run_case(10, 1, "R3 miss mode one block");
    run_case(10, 0, "R3 miss mode hit no trigger");
    run_case(11, 0, "R3 miss mode hit on prefetched block");

    // R4 R5: tagged chain with K=1
    flush(); mode = 1'b1; degree = 4'd1;
    run_case(20, 1, "R4 tagged miss trigger");
    run_case(21, 1, "R5 first use of prefetched block");
    run_case(22, 1, "R5 chain continues");
    run_case(21, 0, "R5 second use no trigger");

    // R3: marked line hit while in miss mode does nothing, marker survives
    mode = 1'b0;
    run_case(23, 0, "R3 marked hit ignored in miss mode");
    mode = 1'b1;
    run_case(23, 1, "R5 marker kept for tagged mode");

    // R2 R6: skip resident candidates
    flush(); degree = 4'd4;
    preload(32); preload(34);
    run_case(30, 2, "R2 R6 skip resident blocks");

    // R7: degree clamp and capture
    flush(); degree = 4'd0;
    run_case(50, 1, "R7 degree zero acts as one");
    flush(); degree = 4'd15;
    hs_cnt = 0;
    access(100);
    degree = 4'd1;
    wait_idle();
    chk(hs_cnt == 8, "R7 degree clamped and captured", hs_cnt, 8);

    // R10: candidates past the top address
    flush(); degree = 4'd4;
    run_case(253, 2, "R10 suppress past top");
    run_case(255, 0, "R10 hit at top no request");
    flush();
    run_case(255, 0, "R10 miss at top no request");

    // R11: stalled requests
    flush(); degree = 4'd8; ready_rand = 1;
    run_case(140, 8, "R11 stalled burst completes");

    // random phase
    for (int n = 0; n < 400; n++) begin
      if (n % 80 == 79) flush();
      mode   = 1'($urandom_range(0, 1));
      degree = 4'($urandom_range(0, 15));
      access(int'($urandom_range(0, NBLK - 1)));
      repeat ($urandom_range(0, 3)) @(posedge clk);
      #1;
    end
    wait_idle();
    ready_rand = 0;
    repeat (4) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule